// File: doc/BRIEF.md
# Register-Mapped NAND Flash Bridge

This block lets a host that only knows 32-bit register reads and writes drive an 8-bit asynchronous NAND flash device. All traffic goes through a single register. A host write names an operation in its top bits, carries a chip-enable request in bit 31 and carries a byte in bits 23:16. The bridge turns that write into a latch cycle on the flash pins. A command byte is latched with CLE high. An address byte is latched with ALE high. A data byte is written with neither. The fourth operation writes nothing to the flash and arms read mode instead.

Once read mode is armed, every host read of the register makes exactly one read strobe on the flash. The byte sampled at the end of that strobe comes back in bits 23:16, so N reads fetch N bytes in sequence. Every read also reports the flash busy state, after synchronization, in bit 15. The host handshake holds `hostReady` low until the flash cycle has finished. Cycle counts for the setup, strobe and hold phases are set by parameters.

The flash I/O bus is split into output, output-enable and input. The output enable is only asserted during write-type cycles.

Top module: `nand_reg_bridge`

## Requirements
- R1: A write with bits 30:28 = 0 runs a command-latch cycle. CLE is high and ALE is low for the whole cycle, and bits 23:16 of the written word are driven on `ioOut` with `ioOe` high.
- R2: A write with bits 30:28 = 1 runs an address-latch cycle. ALE is high, CLE is low, and bits 23:16 are on `ioOut` with `ioOe` high.
- R3: A write with bits 30:28 = 3 runs a data-write cycle. CLE and ALE are both low, and bits 23:16 are on `ioOut` with `ioOe` high.
- R4: Bit 31 of each register write sets the chip enable. `nandCeN` is 0 from the cycle after that write is accepted if bit 31 was 1, and 1 if it was 0. The value holds until the next write.
- R5: A flash cycle has three phases. Setup lasts SETUP_CYC cycles with the strobe high. The strobe is then low for PULSE_CYC cycles. Hold lasts HOLD_CYC cycles with the strobe high. `hostReady` is high for exactly one cycle, right after hold, and is low throughout the flash cycle.
- R6: A write with bits 30:28 = 2 arms read mode, causes no strobe and no bus drive, and completes with `hostReady` in the cycle after acceptance.
- R7: A read while armed makes exactly one `nandReN` low pulse. The byte on `ioIn` in the last low cycle is returned in bits 23:16, so successive reads return successive flash bytes.
- R8: Any write with an opcode other than 2 (including the unused codes 4 to 7) disarms read mode. A read while disarmed returns the last latched byte, makes no `nandReN` pulse, and completes in the cycle after acceptance.
- R9: Read bit 15 is 1 when `nandRbN` is low (busy) and 0 when it is high. The input passes through a two-flop synchronizer first.
- R10: Read bits 31:24 and 14:0 are always 0.
- R11: `ioOe` is high only during the phases of command, address and data-write cycles, and is never high while `nandReN` is low.
- R12: After reset, `nandCeN`, `nandWeN` and `nandReN` are 1, CLE, ALE, `ioOe` and `hostReady` are 0, read mode is disarmed, and the latched byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host request, held until `hostReady` |
| hostWrite | input | 1 | 1 = register write, 0 = register read |
| hostWdata | input | 32 | Register write word |
| hostReady | output | 1 | One-cycle completion of the request |
| hostRdata | output | 32 | Read word: byte in 23:16, busy in bit 15 |
| nandCeN | output | 1 | Flash chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| ioOut | output | 8 | Flash I/O output byte |
| ioOe | output | 1 | Flash I/O output enable |
| ioIn | input | 8 | Flash I/O input byte |
| nandRbN | input | 1 | Flash ready/busy, low = busy |

## Verification
The bench builds the bridge with a setup of 2 cycles, a strobe of 3 cycles and a hold of 1 cycle. Because the three phase lengths differ, an off-by-one in any phase counter, or a swap between two phases, shifts a strobe edge or the ready pulse to a cycle where the per-cycle model disagrees. The flash model puts a filler value on `ioIn` outside the read strobe and a new byte for each strobe. A sample taken at the wrong time, or a second strobe on one read, therefore returns the wrong byte.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
  // operation codes carried in bits 30:28 of a register write
  localparam logic [2:0] OP_CMD  = 3'd0;
  localparam logic [2:0] OP_ADDR = 3'd1;
  localparam logic [2:0] OP_READ = 3'd2;
  localparam logic [2:0] OP_DATA = 3'd3;

  localparam int CE_BIT   = 31;
  localparam int OP_LO    = 28;
  localparam int BYTE_LO  = 16;
  localparam int BUSY_BIT = 15;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;    // request taken this cycle
    logic driveBus;  // inside a write-type flash cycle
    logic weLow;     // write strobe low
    logic reLow;     // read strobe low
    logic sample;    // capture ioIn this cycle
    logic done;      // completion cycle
  } nrb_strb_t;
endpackage

// File: rtl/nrb_ctrl.sv
module nrb_ctrl
  import nrb_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostValid,
  input  logic       hostWrite,
  input  logic [2:0] opcode,
  output nrb_strb_t  strb
);
  localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_CYC = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD, ST_DONE} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             isRd;
  logic             armed;
  logic             busWrite;

  assign busWrite = (opcode == OP_CMD) || (opcode == OP_ADDR) || (opcode == OP_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      isRd  <= 1'b0;
      armed <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hostValid) begin
            if (hostWrite) begin
              armed <= (opcode == OP_READ);
              if (busWrite) begin
                isRd  <= 1'b0;
                state <= ST_SETUP;
                cnt   <= CNT_W'(SETUP_CYC - 1);
              end else begin
                state <= ST_DONE;
              end
            end else if (armed) begin
              isRd  <= 1'b1;
              state <= ST_SETUP;
              cnt   <= CNT_W'(SETUP_CYC - 1);
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_PULSE;
            cnt   <= CNT_W'(PULSE_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PULSE: begin
          if (cnt == '0) begin
            state <= ST_HOLD;
            cnt   <= CNT_W'(HOLD_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == '0) state <= ST_DONE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic inCycle;
  assign inCycle = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);

  always_comb begin
    strb.accept   = (state == ST_IDLE) && hostValid;
    strb.driveBus = inCycle && !isRd;
    strb.weLow    = (state == ST_PULSE) && !isRd;
    strb.reLow    = (state == ST_PULSE) && isRd;
    strb.sample   = (state == ST_PULSE) && isRd && (cnt == '0);
    strb.done     = (state == ST_DONE);
  end

  // R5
  ready_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.done |=> !strb.done);

  // R5
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> !strb.accept);
endmodule

// File: rtl/nrb_datapath.sv
module nrb_datapath
  import nrb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  nrb_strb_t   strb,
  input  logic        hostWrite,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  input  logic [7:0]  ioIn,
  input  logic        nandRbN,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic [7:0]  ioOut,
  output logic        ioOe
);
  logic       ceReg, cleReg, aleReg;
  logic [7:0] outByte, rdByte;
  logic [SYNC_STAGES-1:0] syncChain;
  logic       busySync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceReg   <= 1'b0;
      cleReg  <= 1'b0;
      aleReg  <= 1'b0;
      outByte <= '0;
    end else if (strb.accept && hostWrite) begin
      ceReg   <= hostWdata[CE_BIT];
      cleReg  <= hostWdata[OP_LO +: 3] == OP_CMD;
      aleReg  <= hostWdata[OP_LO +: 3] == OP_ADDR;
      outByte <= hostWdata[BYTE_LO +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdByte <= '0;
    else if (strb.sample) rdByte <= ioIn;
  end

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], ~nandRbN};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= ~nandRbN;
      end
    end
  endgenerate

  assign busySync = syncChain[SYNC_STAGES-1];

  always_comb begin
    hostRdata                = '0;
    hostRdata[BYTE_LO +: 8]  = rdByte;
    hostRdata[BUSY_BIT]      = busySync;
  end

  assign nandCeN = ~ceReg;
  assign nandCle = cleReg & strb.driveBus;
  assign nandAle = aleReg & strb.driveBus;
  assign nandWeN = ~strb.weLow;
  assign nandReN = ~strb.reLow;
  assign ioOe    = strb.driveBus;
  assign ioOut   = outByte;

  // R11
  oe_re_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ioOe && !nandReN));

  // R11
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  // R1
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  // R7
  rd_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |=> $rose(nandReN));

  // R9
  busy_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    busySync |-> !$past(nandRbN, SYNC_STAGES));
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
  import nrb_pkg::*;
#(
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 3,
  parameter int HOLD_CYC    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostValid,
  input  logic        hostWrite,
  input  logic [31:0] hostWdata,
  output logic        hostReady,
  output logic [31:0] hostRdata,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic [7:0]  ioOut,
  output logic        ioOe,
  input  logic [7:0]  ioIn,
  input  logic        nandRbN
);
  nrb_strb_t strb;

  nrb_ctrl #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .opcode(hostWdata[OP_LO +: 3]), .strb(strb)
  );

  nrb_datapath #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWrite(hostWrite),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .ioIn(ioIn), .nandRbN(nandRbN),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .ioOut(ioOut), .ioOe(ioOe)
  );

  assign hostReady = strb.done;
endmodule

// File: tb/tb_nand_reg_bridge.sv
module tb_nand_reg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int S = 2, P = 3, H = 1;

  logic clk = 0, rstN = 0;
  logic hostValid = 0, hostWrite = 0;
  logic [31:0] hostWdata = '0;
  logic hostReady;
  logic [31:0] hostRdata;
  logic nandCeN, nandCle, nandAle, nandWeN, nandReN, ioOe;
  logic [7:0] ioOut, ioIn;
  logic nandRbN = 1;

  int vectors = 0, miscompares = 0;
  logic [7:0] flashPtr = '0;
  logic prevReN = 1;

  // model state
  logic expCe = 0, armedM = 0;
  logic [7:0] lastByte = '0;
  int rdCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_reg_bridge #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) dut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostWrite(hostWrite),
    .hostWdata(hostWdata), .hostReady(hostReady), .hostRdata(hostRdata),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn), .nandRbN(nandRbN)
  );

  // flash model: a new byte per read strobe, filler outside it
  assign ioIn = !nandReN ? 8'(8'h30 + flashPtr * 8'd7) : 8'hEE;
  always @(posedge clk) begin
    prevReN <= nandReN;
    if (rstN && nandReN && !prevReN) flashPtr <= flashPtr + 1'b1;
  end

  logic cycBad;
  task automatic fld(string req, string name, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      cycBad = 1;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic cmpPins(string reqOp, string reqRe, logic cle, logic ale, logic weN,
                         logic reN, logic oe, logic [7:0] ob, logic rdy);
    cycBad = 0;
    fld("R4", "nandCeN", 32'(nandCeN), 32'(!expCe));
    fld(reqOp, "nandCle", 32'(nandCle), 32'(cle));
    fld(reqOp, "nandAle", 32'(nandAle), 32'(ale));
    fld("R5", "nandWeN", 32'(nandWeN), 32'(weN));
    fld(reqRe, "nandReN", 32'(nandReN), 32'(reN));
    fld("R11", "ioOe", 32'(ioOe), 32'(oe));
    if (oe) fld(reqOp, "ioOut", 32'(ioOut), 32'(ob));
    fld("R5", "hostReady", 32'(hostReady), 32'(rdy));
    vectors++;
    if (cycBad) miscompares++;
  endtask

  task automatic idleCycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmpPins("R12", "R8", 0, 0, 1, 1, 0, 8'h00, 0);
    end
  endtask

  task automatic hostOp(logic wr, logic [31:0] word);
    logic [2:0] op;
    logic flashWr, flashRd;
    logic [7:0] b;
    int total;
    string reqOp;
    op = word[30:28];
    b = word[23:16];
    flashWr = wr && (op == 3'd0 || op == 3'd1 || op == 3'd3);
    flashRd = !wr && armedM;
    reqOp = (op == 3'd0) ? "R1" : (op == 3'd1) ? "R2" : (op == 3'd3) ? "R3" : "R6";
    @(negedge clk);
    hostValid = 1; hostWrite = wr; hostWdata = word;
    if (wr) begin
      expCe = word[31];
      armedM = (op == 3'd2);
    end
    total = (flashWr || flashRd) ? S + P + H : 0;
    for (int i = 0; i <= total; i++) begin
      @(negedge clk);
      if (i == total) begin
        cmpPins(wr ? reqOp : "R8", flashRd ? "R7" : "R8", 0, 0, 1, 1, 0, 8'h00, 1);
        if (!wr) begin
          if (flashRd) begin
            lastByte = 8'(8'h30 + rdCount * 7);
            rdCount++;
          end
          cycBad = 0;
          fld(flashRd ? "R7" : "R8", "rdata byte", 32'(hostRdata[23:16]), 32'(lastByte));
          fld("R9", "rdata busy", 32'(hostRdata[15]), 32'(!nandRbN));
          fld("R10", "rdata unused", {hostRdata[31:24], 9'h0, hostRdata[14:0]}, 32'h0);
          vectors++;
          if (cycBad) miscompares++;
        end
        hostValid = 0; hostWrite = 0; hostWdata = '0;
      end else begin
        logic pulse;
        pulse = (i >= S) && (i < S + P);
        if (flashWr)
          cmpPins(reqOp, "R11", op == 3'd0, op == 3'd1, !pulse, 1, 1, b, 0);
        else
          cmpPins("R7", "R7", 0, 0, 1, !pulse, 0, 8'h00, 0);
      end
    end
  endtask

  function automatic logic [31:0] mk(logic ce, logic [2:0] op, logic [7:0] b);
    // bits 27:24 and 15:0 carry junk that must be ignored
    return {ce, op, 4'hA, b, 16'h5A3C};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    $display("FAIL watchdog: actual running expected finished");
    miscompares++; vectors++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R12 reset state
    idleCycles(2);
    hostOp(1, mk(1, 3'd0, 8'h90));   // R1 command
    idleCycles(1);
    hostOp(1, mk(1, 3'd1, 8'h12));   // R2 address
    hostOp(1, mk(1, 3'd1, 8'h34));
    hostOp(1, mk(1, 3'd3, 8'hA5));   // R3 data
    hostOp(1, mk(0, 3'd0, 8'hFF));   // R4 ce off
    idleCycles(1);
    hostOp(0, 32'h0);                // R8 read unarmed: 0, no strobe
    hostOp(1, mk(1, 3'd2, 8'h00));   // R6 arm
    hostOp(0, 32'h0);                // R7 sequential reads
    hostOp(0, 32'h0);
    hostOp(0, 32'h0);
    nandRbN = 0; idleCycles(4);      // R9 busy
    hostOp(0, 32'h0);
    nandRbN = 1; idleCycles(4);
    hostOp(0, 32'h0);
    hostOp(1, mk(1, 3'd5, 8'h77));   // R8 unused code disarms
    hostOp(0, 32'h0);
    hostOp(1, mk(1, 3'd2, 8'h00));
    hostOp(0, 32'h0);
    hostOp(1, mk(1, 3'd3, 8'h3C));   // R8 data write disarms
    hostOp(0, 32'h0);
    nandRbN = 0; idleCycles(4);
    hostOp(0, 32'h0);                // R9 busy on unarmed read
    nandRbN = 1;
    idleCycles(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule